// File: doc/BRIEF.md
# ISA I/O Wait-State Generator

This block lengthens 8-bit ISA I/O cycles that target a two-port bridge window, so that a slow peripheral behind the bridge can keep pace with a fast host. It watches the DMA address-enable line, the I/O port address and the active-low read and write strobes on every rising edge of the bus clock. When an access lands on the port pair, it pulls the channel-ready line low for a fixed number of bus clocks. It then releases the line so the host can complete the cycle.

A terminal-count indication closes each wait and clears the delay counter. After that the generator stays idle until the strobe that started the wait has been withdrawn, so a single long strobe never produces a second wait. A synchronous active-low reset clears the counter and returns the generator to idle. While reset is held low, the ready output is driven high directly, without waiting for a clock edge.

Top module: `isa_wait_stretcher`

## Requirements
- R1: An access qualifies when `aen` is 0, `io_addr[9:1]` equals `BASE_ADDR[9:1]` (default base 220h), and `ior_n` or `iow_n` is 0. If a qualified access is sampled at a rising edge while the generator is idle, `io_ready` is 0 from that edge onward.
- R2: A wait holds `io_ready` at 0 for exactly `WAIT_CYCLES` clock cycles (default 5). After that, `io_ready` returns to 1.
- R3: While `aen` is 1, the generator starts no wait, whatever the address or strobes are.
- R4: Port addresses 220h and 221h both start a wait. Any address whose bits 9..1 differ from the base, such as 222h or 21Fh, starts no wait.
- R5: A read strobe (`ior_n`=0) and a write strobe (`iow_n`=0) each start a wait on their own.
- R6: A strobe that stays asserted after its wait ends starts no further wait. A new wait can begin at the first edge after an edge at which both strobes were sampled high.
- R7: While `rst_n` is 0, `io_ready` is 1 without waiting for a clock edge. A reset edge clears the counter and leaves the generator idle.
- R8: A reset applied during a wait aborts that wait. The next qualified access after reset gets the full `WAIT_CYCLES` wait.
- R9: `io_ready` is 1 whenever no wait is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ISA bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also forces `io_ready` high directly |
| aen | input | 1 | DMA address enable; 1 disqualifies I/O decode |
| io_addr | input | ADDR_W | I/O port address |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| io_ready | output | 1 | Channel ready; 0 stretches the current I/O cycle |

## Verification
The bench counts the exact length of every low pulse on the ready line. A counter off by one in either direction shows up as one extra or one missing low cycle. It holds strobes asserted for two cycles past the wait's end, which catches a design that re-arms while the strobe is still active. It also separates accesses by a single high cycle, which catches a design that needs a longer gap. Addresses just outside the port pair (222h, 21Fh) and DMA-owned cycles must leave the ready line high, so a loose compare or an ignored `aen` produces a spurious wait. Finally, reset is asserted mid-wait. The ready line must go high before the next edge, and the following access must get a full-length wait rather than the remainder of the aborted one.

// File: rtl/isa_wait_pkg.sv
// Shared types for the ISA wait-state generator.
// Assumes: consumers only need the sequencer state encoding.
package isa_wait_pkg;

    typedef enum logic [1:0] {
        WS_IDLE    = 2'd0,   // waiting for a qualified access
        WS_STRETCH = 2'd1,   // holding the channel-ready line low
        WS_RELEASE = 2'd2    // wait done, waiting for the strobe to drop
    } ws_state_e;

endpackage

// File: rtl/isa_port_match.sv
// Address and strobe decode for the bridge's two-port window.
// Matches the port pair by ignoring address bit 0 and qualifies the match with
// a low DMA enable and either I/O strobe. Purely combinational.
// Assumes: strobes are active-low and already in the bus-clock domain.
module isa_port_match #(
    parameter int          ADDR_W    = 10,
    parameter logic [9:0]  BASE_ADDR = 10'h220
) (
    input  logic              aen,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              ior_n,
    input  logic              iow_n,
    output logic              strobe,
    output logic              qualified
);

    localparam int PAIR_W = ADDR_W - 1;
    localparam logic [PAIR_W-1:0] PAIR_TAG = BASE_ADDR[ADDR_W-1:1];

    logic window_hit;

    // Compare everything above bit 0 so both ports of the pair hit.
    always_comb begin
        window_hit = (io_addr[ADDR_W-1:1] == PAIR_TAG) && !aen;
        strobe     = !ior_n || !iow_n;
        qualified  = window_hit && strobe;
    end

endmodule

// File: rtl/isa_wait_counter.sv
// Wait-length down counter.
// A load starts it at WAIT_CYCLES-1; it then counts down to zero and holds
// there. A clear (terminal count) or reset forces it to zero.
// Assumes: load and clear are never asserted together by the sequencer.
module isa_wait_counter #(
    parameter int WAIT_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    output logic cnt_zero
);

    localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load, clear or step the counter once per bus clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (clear)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_zero = (cnt_q == '0);

    // The count never exceeds the programmed wait length.
    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL);

    // A load always leaves a non-zero count unless the wait is one cycle.
    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/isa_wait_stretcher.sv
// ISA I/O wait-state generator (top).
// Starts a fixed-length wait on each qualified access to the port pair, pulls
// io_ready low for WAIT_CYCLES bus clocks, then waits for the strobe to drop
// before re-arming. Reset clears the state and forces io_ready high at once.
// Assumes: inputs are synchronous to clk; WAIT_CYCLES >= 1.
module isa_wait_stretcher
    import isa_wait_pkg::*;
#(
    parameter int          ADDR_W      = 10,
    parameter logic [9:0]  BASE_ADDR   = 10'h220,
    parameter int          WAIT_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aen,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              ior_n,
    input  logic              iow_n,
    output logic              io_ready
);

    localparam int RUN_W = $clog2(WAIT_CYCLES + 1) + 1;

    ws_state_e state_q;
    logic      strobe;
    logic      qualified;
    logic      cnt_zero;
    logic      start_wait;
    logic      term_cnt;
    logic      hold;

    isa_port_match #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_match (
        .aen       (aen),
        .io_addr   (io_addr),
        .ior_n     (ior_n),
        .iow_n     (iow_n),
        .strobe    (strobe),
        .qualified (qualified)
    );

    // Sequencer handshakes to the counter: start on a fresh access, clear at end.
    always_comb begin
        start_wait = (state_q == WS_IDLE) && qualified;
        term_cnt   = (state_q == WS_STRETCH) && cnt_zero;
        hold       = (state_q == WS_STRETCH);
    end

    isa_wait_counter #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_wait),
        .clear    (term_cnt),
        .cnt_zero (cnt_zero)
    );

    // Sequencer: idle -> stretch -> release -> idle once the strobe is gone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            unique case (state_q)
                WS_IDLE:    if (qualified) state_q <= WS_STRETCH;
                WS_STRETCH: if (term_cnt)  state_q <= WS_RELEASE;
                WS_RELEASE: if (!strobe)   state_q <= WS_IDLE;
                default:                   state_q <= WS_IDLE;
            endcase
        end
    end

    // Ready is high unless stretching; reset overrides without a clock edge.
    assign io_ready = !hold || !rst_n;

    // ---------------- assertions ----------------

    // Length of the current low run, for the wait-length checks.
    logic [RUN_W-1:0] chk_low_run;

    // Count consecutive edges at which the wait was active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_low_run <= '0;
        else if (hold)
            chk_low_run <= chk_low_run + 1'b1;
        else
            chk_low_run <= '0;
    end

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_IDLE && qualified) |=> !io_ready);

    assert_wait_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && chk_low_run != '0) |-> (chk_low_run == RUN_W'(WAIT_CYCLES)));

    assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (chk_low_run < RUN_W'(WAIT_CYCLES)));

    assert_dma_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_ready && aen) |=> io_ready);

    assert_single_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(io_ready) && strobe) |=> io_ready);

    // Reset forces the ready line high without an edge.
    always_comb begin
        if (rst_n === 1'b0)
            assert_reset_ready_R7: assert (io_ready);
    end

endmodule

// File: tb/isa_wait_stretcher_test.sv
// Scoreboard bench: driver tasks queue the expected io_ready per cycle,
// a monitor pops and compares after each rising edge.
module isa_wait_stretcher_test;

    localparam int W = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aen = 1'b0;
    logic [9:0] addr = 10'h000;
    logic       ior_n = 1'b1;
    logic       iow_n = 1'b1;
    logic       rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    isa_wait_stretcher #(.WAIT_CYCLES(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .aen      (aen),
        .io_addr  (addr),
        .ior_n    (ior_n),
        .iow_n    (iow_n),
        .io_ready (rdy)
    );

    // Monitor: compare io_ready against the queued expectation after each edge.
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdy !== e) begin
                fails++;
                $display("FAIL %s: io_ready=%0b expected %0b", t, rdy, e);
            end
        end
    end

    // Drive one cycle of inputs and queue the io_ready seen after the next edge.
    task automatic step(input bit r, input bit a, input logic [9:0] ad,
                        input bit rd_n, input bit wr_n, input bit e, input string t);
        @(negedge clk);
        rst_n = r; aen = a; addr = ad; ior_n = rd_n; iow_n = wr_n;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // One access: strobe held for W+2 cycles, then 'gap' idle cycles.
    task automatic access(input bit a, input logic [9:0] ad, input bit rd,
                          input bit wr, input bit qual, input int gap, input string t);
        for (int i = 1; i <= W + 2; i++)
            step(1'b1, a, ad, !rd, !wr, (qual && i <= W) ? 1'b0 : 1'b1, t);
        for (int g = 0; g < gap; g++)
            step(1'b1, 1'b0, ad, 1'b1, 1'b1, 1'b1, {t, " R9 idle"});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R7: reset state, ready high while reset is held.
        step(1'b0, 1'b0, 10'h220, 1'b0, 1'b1, 1'b1, "R7 reset");
        step(1'b0, 1'b0, 10'h000, 1'b1, 1'b1, 1'b1, "R7 reset");
        step(1'b1, 1'b0, 10'h000, 1'b1, 1'b1, 1'b1, "R9 idle after reset");

        // R1 R2 R6: read of 220h, strobe kept past the wait.
        access(1'b0, 10'h220, 1'b1, 1'b0, 1'b1, 2, "R1 R2 R6 read 220h");
        // R4 R5: write of 221h.
        access(1'b0, 10'h221, 1'b0, 1'b1, 1'b1, 2, "R4 R5 write 221h");
        // R3: DMA cycle to the window.
        access(1'b1, 10'h220, 1'b1, 1'b0, 1'b0, 1, "R3 aen high");
        access(1'b1, 10'h221, 1'b0, 1'b1, 1'b0, 1, "R3 aen high write");
        // R4: neighbouring addresses.
        access(1'b0, 10'h222, 1'b1, 1'b0, 1'b0, 1, "R4 addr 222h");
        access(1'b0, 10'h21F, 1'b0, 1'b1, 1'b0, 1, "R4 addr 21Fh");
        // R6: back-to-back with a single high cycle between strobes.
        access(1'b0, 10'h220, 1'b0, 1'b1, 1'b1, 1, "R6 back-to-back first");
        access(1'b0, 10'h221, 1'b1, 1'b0, 1'b1, 1, "R6 back-to-back second");

        // R7 R8: reset during a wait.
        step(1'b1, 1'b0, 10'h220, 1'b0, 1'b1, 1'b0, "R8 wait before reset");
        step(1'b1, 1'b0, 10'h220, 1'b0, 1'b1, 1'b0, "R8 wait before reset");
        @(negedge clk);
        rst_n = 1'b0; ior_n = 1'b1;
        #1;
        checks++;
        if (rdy !== 1'b1) begin
            fails++;
            $display("FAIL R7 async ready: io_ready=%0b expected 1", rdy);
        end
        exp_q.push_back(1'b1);
        tag_q.push_back("R7 reset mid-wait");
        step(1'b1, 1'b0, 10'h000, 1'b1, 1'b1, 1'b1, "R8 idle after reset");
        access(1'b0, 10'h220, 1'b1, 1'b0, 1'b1, 2, "R8 full wait after reset");

        step(1'b1, 1'b0, 10'h000, 1'b1, 1'b1, 1'b1, "R9 final idle");
        @(negedge clk);
        wait (exp_q.size() == 0);
        #5;
        finish_run();
    end

endmodule